// File: doc/BRIEF.md
# Write-only I2C configuration target for a video crosspoint

This block is a bus target that listens on a Standard-Mode I2C bus (up to 100 kHz) and only accepts writes. It samples SCL and SDA with a much faster system clock, finds START and STOP, and checks the address byte. A transaction carries an address byte, a register pointer byte and then one or more data bytes. Each byte lands in a small register file that steers a video crosspoint. The register contents drive parallel configuration buses: a 4-bit input selector per output, a clamp-or-bias flag per input, and a gain flag per output.

The target answers to an address byte of 0x06 when both strap pins are low. The two strap pins supply the two upper bits of the address byte. The target drives SDA only as an open-drain pull-down enable, and it has no read path.

Top module: `xbar_cfg_i2c_target`

## Requirements
- R1: The write address byte is {strap_hi, strap_lo, 6'b000110}, which gives 0x06, 0x46, 0x86 or 0xC6. A matching byte is acknowledged by holding SDA low during the ninth SCL pulse.
- R2: An address byte that does not match, or that has bit 0 (R/W) set to 1, is not acknowledged. All following bytes are then ignored and left unacknowledged until the next START or STOP, and no register changes.
- R3: The address, pointer and data bytes are each acknowledged, and SDA stays low across the whole high phase of the ninth clock.
- R4: Pointers 0x00, 0x01 and 0x02 hold the selectors for output pairs (1,2), (3,4) and (5,6). The odd-numbered output of each pair takes data bits 3:0 and the even-numbered output takes bits 7:4. Output k drives route_sel_o[4k-1:4k-4].
- R5: Pointer 0x03 holds one flag per input, with bit n-1 belonging to input n, and drives clamp_o (1 = clamp, 0 = bias).
- R6: Pointer 0x04 bits 5:0 drive gain_o for outputs 1 to 6. Bits 7:6 are discarded.
- R7: A write to any pointer from 0x05 to 0xFF is acknowledged and changes no output.
- R8: Reset clears every configuration output to 0 and releases SDA.
- R9: Each further data byte in the same transaction goes to the previous pointer plus one, and the pointer wraps from 0xFF to 0x00.
- R10: A repeated START abandons the current transaction and restarts address matching.
- R11: The SDA pull-down enable changes only while the synchronized SCL is low.
- R12: A register keeps its old value through the acknowledge clock of its data byte. It takes the new value a few system cycles after that clock falls, and it never changes without a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_hi | input | 1 | Strap for address-byte bit 7 |
| strap_lo | input | 1 | Strap for address-byte bit 6 |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| route_sel_o | output | 24 | Six 4-bit input selectors, output 1 in the low nibble |
| clamp_o | output | 8 | Clamp (1) or bias (0) per input |
| gain_o | output | 6 | Gain flag per output |

## Verification
The data-byte commit and the pointer advance fall in the same system cycle, on the falling edge of the acknowledge clock. Whether the next byte of a burst lands correctly depends on both happening together. The bench provokes this with bursts that run from 0x04 into the undefined 0x05 and from 0xFF round to 0x00. It judges the result on the configuration buses against a bench-side register model. A second coincidence is a repeated START arriving while the target is ignoring a mismatched address; it is judged by whether the following correct write takes effect.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 4;
    localparam int BIT_CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DATA,
        ST_SKIP
    } eng_state_t;

    typedef struct packed {
        logic              stb;
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // Full write address byte: straps on top, fixed bits below, R/W = 0.
    function automatic logic [BYTE_W-1:0] target_byte(
        input logic [4:0] fixed_bits,
        input logic       hi,
        input logic       lo
    );
        return {hi, lo, fixed_bits, 1'b0};
    endfunction

    function automatic logic addr_hit(
        input logic [BYTE_W-1:0] rx,
        input logic [4:0]        fixed_bits,
        input logic              hi,
        input logic              lo
    );
        return rx == target_byte(fixed_bits, hi, lo);
    endfunction

endpackage

// File: rtl/xcfg_line_sync.sv
module xcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain   <= '1;
                    prev[g] <= 1'b1;
                end else begin
                    chain   <= {chain[STAGES-2:0], raw[g]};
                    prev[g] <= chain[STAGES-1];
                end
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/xcfg_wr_engine.sv
module xcfg_wr_engine
    import xcfg_pkg::*;
#(
    parameter logic [4:0] ADDR_FIXED = 5'b00011
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sda_s,
    input  logic    scl_rise,
    input  logic    scl_fall,
    input  logic    start_det,
    input  logic    stop_det,
    input  logic    strap_hi,
    input  logic    strap_lo,
    output logic    sda_oe,
    output wr_req_t wr
);
    localparam logic [BIT_CNT_W-1:0] CNT_BYTE = BIT_CNT_W'(8);
    localparam logic [BIT_CNT_W-1:0] CNT_ACK  = BIT_CNT_W'(9);

    eng_state_t           state;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    ptr_q;
    logic                 receiving;

    assign receiving = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr_q   <= '0;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.stb <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (receiving) begin
                if (scl_rise && bit_cnt < CNT_BYTE) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall && bit_cnt == CNT_BYTE) begin
                    if (state != ST_ADDR || addr_hit(shreg, ADDR_FIXED, strap_hi, strap_lo)) begin
                        sda_oe  <= 1'b1;
                        bit_cnt <= CNT_ACK;
                    end else begin
                        state   <= ST_SKIP;
                        bit_cnt <= '0;
                    end
                end else if (scl_fall && bit_cnt == CNT_ACK) begin
                    sda_oe  <= 1'b0;
                    bit_cnt <= '0;
                    unique case (state)
                        ST_ADDR: state <= ST_PTR;
                        ST_PTR: begin
                            ptr_q <= shreg;
                            state <= ST_DATA;
                        end
                        default: begin
                            wr.stb  <= 1'b1;
                            wr.ptr  <= ptr_q;
                            wr.data <= shreg;
                            ptr_q   <= ptr_q + 1'b1;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/xcfg_cfg_regs.sv
module xcfg_cfg_regs
    import xcfg_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter int NUM_IN  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    output logic [NUM_OUT*SEL_W-1:0] route_sel_o,
    output logic [NUM_IN-1:0]        clamp_o,
    output logic [NUM_OUT-1:0]       gain_o
);
    localparam int PER_REG    = BYTE_W / SEL_W;
    localparam int ROUTE_REGS = (NUM_OUT + PER_REG - 1) / PER_REG;
    localparam logic [BYTE_W-1:0] CLAMP_PTR = BYTE_W'(ROUTE_REGS);
    localparam logic [BYTE_W-1:0] GAIN_PTR  = BYTE_W'(ROUTE_REGS + 1);

    logic [BYTE_W-1:0] route_q [ROUTE_REGS];

    genvar r, k;
    generate
        for (r = 0; r < ROUTE_REGS; r++) begin : g_route
            always_ff @(posedge clk) begin
                if (rst)
                    route_q[r] <= '0;
                else if (wr.stb && wr.ptr == BYTE_W'(r))
                    route_q[r] <= wr.data;
            end
        end
        for (k = 0; k < NUM_OUT; k++) begin : g_sel
            assign route_sel_o[k*SEL_W +: SEL_W] = route_q[k/PER_REG][(k%PER_REG)*SEL_W +: SEL_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_o <= '0;
            gain_o  <= '0;
        end else if (wr.stb) begin
            if (wr.ptr == CLAMP_PTR) clamp_o <= wr.data[NUM_IN-1:0];
            if (wr.ptr == GAIN_PTR)  gain_o  <= wr.data[NUM_OUT-1:0];
        end
    end

endmodule

// File: rtl/xbar_cfg_i2c_target.sv
module xbar_cfg_i2c_target
    import xcfg_pkg::*;
#(
    parameter int         NUM_OUT     = 6,
    parameter int         NUM_IN      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] ADDR_FIXED  = 5'b00011
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic                     strap_hi,
    input  logic                     strap_lo,
    output logic                     sda_oe,
    output logic [NUM_OUT*SEL_W-1:0] route_sel_o,
    output logic [NUM_IN-1:0]        clamp_o,
    output logic [NUM_OUT-1:0]       gain_o
);
    logic    scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    wr_req_t wr;

    xcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    xcfg_wr_engine #(.ADDR_FIXED(ADDR_FIXED)) u_eng (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .strap_hi(strap_hi), .strap_lo(strap_lo),
        .sda_oe(sda_oe), .wr(wr)
    );

    xcfg_cfg_regs #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_regs (
        .clk(clk), .rst(rst), .wr(wr),
        .route_sel_o(route_sel_o), .clamp_o(clamp_o), .gain_o(gain_o)
    );

endmodule

// File: rtl/xbar_cfg_i2c_chk.sv
module xbar_cfg_i2c_chk
    import xcfg_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter int NUM_IN  = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     scl_s,
    input logic                     start_det,
    input logic                     sda_oe,
    input wr_req_t                  wr,
    input logic [NUM_OUT*SEL_W-1:0] route_sel_o,
    input logic [NUM_IN-1:0]        clamp_o,
    input logic [NUM_OUT-1:0]       gain_o
);
    localparam int LAST_PTR = (NUM_OUT + 1) / 2 + 1;

    logic [NUM_OUT*SEL_W+NUM_IN+NUM_OUT-1:0] cfg;
    assign cfg = {route_sel_o, clamp_o, gain_o};

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (cfg == '0 && !sda_oe));

    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    assert_hold_no_write_R12: assert property (@(posedge clk) disable iff (rst)
        !wr.stb |=> $stable(cfg));

    assert_undef_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        (wr.stb && wr.ptr > BYTE_W'(LAST_PTR)) |=> $stable(cfg));

    assert_start_release_R10: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

endmodule

bind xbar_cfg_i2c_target xbar_cfg_i2c_chk #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) chk_i (
    .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det), .sda_oe(sda_oe),
    .wr(wr), .route_sel_o(route_sel_o), .clamp_o(clamp_o), .gain_o(gain_o)
);

// File: tb/xbar_cfg_i2c_target_test.sv
module xbar_cfg_i2c_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap_hi = 1'b0;
    logic strap_lo = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic [23:0] route_sel_o;
    logic [7:0]  clamp_o;
    logic [5:0]  gain_o;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_cfg_i2c_target uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_hi(strap_hi), .strap_lo(strap_lo), .sda_oe(sda_oe),
        .route_sel_o(route_sel_o), .clamp_o(clamp_o), .gain_o(gain_o)
    );

    int checks = 0;
    int fails  = 0;
    int oe_violations = 0;
    bit done = 0;

    logic [3:0] exp_route [6];
    logic [7:0] exp_clamp;
    logic [5:0] exp_gain;
    logic [7:0] buf_b [8];
    bit         probe_en = 0;
    logic [5:0] probe_gain;

    // R11 monitor: pull-down changes only while master holds SCL low
    always @(sda_oe) if (!rst && scl_m) oe_violations++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] exp_route_vec();
        logic [23:0] v;
        for (int i = 0; i < 6; i++) v[i*4 +: 4] = exp_route[i];
        return v;
    endfunction

    function automatic void model_write(input logic [7:0] p, input logic [7:0] d);
        if (p <= 8'd2) begin
            exp_route[2*p]   = d[3:0];
            exp_route[2*p+1] = d[7:4];
        end else if (p == 8'd3) exp_clamp = d;
        else if (p == 8'd4) exp_gain = d[5:0];
    endfunction

    task automatic check_cfg(input string req);
        chk(route_sel_o == exp_route_vec(), req, route_sel_o, exp_route_vec());
        chk(clamp_o == exp_clamp, req, clamp_o, exp_clamp);
        chk(gain_o == exp_gain, req, gain_o, exp_gain);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    // R3: ack sampled at start and end of the ninth high phase
    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit a0, a1;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(1);
        a0 = !sda_bus;
        if (probe_en) chk(gain_o == probe_gain, "R12 old value during ack", gain_o, probe_gain);
        tick(2*Q - 2);
        a1 = !sda_bus;
        tick(1);
        scl_m = 1'b0; tick(Q);
        acked = a0 && a1;
        if (a0 != a1) chk(0, "R3 ack not held over high phase", a1, a0);
    endtask

    task automatic do_write(input logic [7:0] abyte, input logic [7:0] p, input int n,
                            input bit expect_ack, input string req);
        bit a;
        bus_start();
        send_byte(abyte, a);
        chk(a == expect_ack, {req, " addr ack"}, a, expect_ack);
        send_byte(p, a);
        chk(a == expect_ack, {req, " ptr ack"}, a, expect_ack);
        for (int i = 0; i < n; i++) begin
            send_byte(buf_b[i], a);
            chk(a == expect_ack, {req, " data ack"}, a, expect_ack);
            if (expect_ack) model_write(p + 8'(i), buf_b[i]);
        end
        bus_stop();
    endtask

    function automatic logic [7:0] my_addr();
        return {strap_hi, strap_lo, 6'b000110};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a;
        for (int i = 0; i < 6; i++) exp_route[i] = '0;
        exp_clamp = '0;
        exp_gain  = '0;
        tick(5);
        rst = 1'b0;
        tick(3);
        // R8 reset state
        check_cfg("R8 reset");
        chk(sda_oe == 1'b0, "R8 sda released", sda_oe, 0);

        // R1/R2 strap sweep with single-bit address corruptions
        for (int s = 0; s < 4; s++) begin
            strap_hi = s[1];
            strap_lo = s[0];
            buf_b[0] = 8'(s * 13 + 5);
            do_write(my_addr(), 8'd4, 1, 1, "R1 strap match");
            tick(4);
            check_cfg("R1 gain after matched write");
            for (int k = 0; k < 8; k++) begin
                buf_b[0] = 8'h3F;
                do_write(my_addr() ^ (8'd1 << k), 8'd4, 1, 0, "R2 mismatch/read");
                tick(4);
                check_cfg("R2 no change after nack");
            end
        end
        strap_hi = 1'b0;
        strap_lo = 1'b0;

        // R4 route packing sweep, 3-byte bursts (R9)
        for (int v = 0; v < 16; v++) begin
            buf_b[0] = {4'(v ^ 15), 4'(v)};
            buf_b[1] = {4'(v + 3), 4'(v + 7)};
            buf_b[2] = {4'(v * 5), 4'(v + 11)};
            do_write(8'h06, 8'd0, 3, 1, "R4 route burst");
            tick(4);
            check_cfg("R4 R9 route nibbles");
        end

        // R5 clamp walking one
        for (int n = 0; n < 8; n++) begin
            buf_b[0] = 8'd1 << n;
            do_write(8'h06, 8'd3, 1, 1, "R5 clamp");
            tick(4);
            chk(clamp_o == (8'd1 << n), "R5 clamp bit n-1 for input n", clamp_o, 8'd1 << n);
        end

        // R6 gain upper bits discarded
        buf_b[0] = 8'hFF;
        do_write(8'h06, 8'd4, 1, 1, "R6 gain");
        tick(4);
        chk(gain_o == 6'h3F, "R6 gain all ones", gain_o, 6'h3F);
        buf_b[0] = 8'hC0;
        do_write(8'h06, 8'd4, 1, 1, "R6 gain");
        tick(4);
        chk(gain_o == 6'h00, "R6 bits 7:6 unused", gain_o, 6'h00);

        // R7 undefined pointers
        foreach (buf_b[i]) buf_b[i] = 8'hA5;
        do_write(8'h06, 8'd5, 1, 1, "R7 undefined 0x05");
        do_write(8'h06, 8'h80, 1, 1, "R7 undefined 0x80");
        do_write(8'h06, 8'hFE, 1, 1, "R7 undefined 0xFE");
        tick(4);
        check_cfg("R7 no effect");

        // R9 pointer wrap and commit at boundary 0x04 -> 0x05
        buf_b[0] = 8'h11; buf_b[1] = 8'h9C;
        do_write(8'h06, 8'hFF, 2, 1, "R9 wrap");
        tick(4);
        check_cfg("R9 0xFF dropped, next to 0x00");
        buf_b[0] = 8'h15; buf_b[1] = 8'h3F;
        do_write(8'h06, 8'd4, 2, 1, "R9 past last");
        tick(4);
        check_cfg("R9 gain then 0x05 dropped");

        // R10 repeated START after a mismatched address
        bus_start();
        send_byte(8'h46, a);
        chk(a == 0, "R10 wrong addr nack", a, 0);
        bus_start();
        send_byte(8'h06, a);
        chk(a == 1, "R10 restart addr ack", a, 1);
        send_byte(8'd3, a);
        send_byte(8'h5A, a);
        model_write(8'd3, 8'h5A);
        bus_stop();
        tick(4);
        check_cfg("R10 write after repeated start");

        // R12 old value held through ack of data byte
        bus_start();
        send_byte(8'h06, a);
        send_byte(8'd4, a);
        probe_en = 1;
        probe_gain = exp_gain;
        send_byte(8'h2A, a);
        probe_en = 0;
        model_write(8'd4, 8'h2A);
        chk(gain_o == 6'h2A, "R12 new value after ack fall", gain_o, 6'h2A);
        bus_stop();

        // R11 summary of monitor
        chk(oe_violations == 0, "R11 sda_oe changed while SCL high", oe_violations, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule